// File: doc/BRIEF.md
# SDRAM Write Burst Column Sequencer

This block is the write-side burst engine inside a synchronous DRAM device model. Each clock it decodes the command pins. When it sees a WRITE, it latches the bank, the starting column and the auto-precharge flag, and writes the first data word on that same clock edge. On each following edge it drives one column address and one write strobe into a plain synchronous memory array until the burst ends.

A burst is either a programmed fixed length or a full-page run that wraps at the top column. A fixed burst steps through its column block in sequential or interleaved order. A new WRITE on any clock cuts the current burst short and starts its own burst at once. Any other command ends a burst without writing. When auto precharge was requested and the burst finishes normally, a one-cycle precharge request that carries the bank follows the last word. Burst length and burst order are static inputs.

Top module: `sdram_wr_burst_seq`

## Requirements
- R1: A WRITE is decoded when cke=1, cs_n=0, ras_n=1, cas_n=0 and we_n=0. In that same cycle mem_we=1, mem_col=col_addr, mem_bank=ba and mem_wdata=dq_in.
- R2: burst_sel 0,1,2,3 selects fixed bursts of 1, 2, 4 and 8 words, and burst_sel 4 to 7 selects a full-page burst. The words of one burst are written on consecutive cycles with no gap, and a fixed burst writes exactly its length. mem_bank holds the latched bank and mem_wdata follows dq_in.
- R3: With burst_ilv=0, word i of a fixed burst of length L writes the column (start - start mod L) + ((start mod L + i) mod L).
- R4: With burst_ilv=1, word i of a fixed burst writes the column (start - start mod L) + ((start mod L) XOR i).
- R5: After the last word of a fixed burst, mem_we stays 0 until the next WRITE, and dq_in is ignored.
- R6: In a full-page burst, word i writes the column (start + i) mod 2^COL_W. The burst runs until a command ends it, and burst_ilv has no effect on it.
- R7: A WRITE on any cycle of a running burst ends that burst. The new burst writes its first word in the command cycle, to any bank.
- R8: NOP (cs_n=0, ras_n=cas_n=we_n=1) and deselect (cs_n=1) leave a running burst undisturbed. Any other command with cs_n=0 and cke=1 ends the burst and writes nothing.
- R9: When a burst started with auto_pre=1 writes its last word, pre_req is 1 for one cycle in the following cycle, with pre_bank equal to the burst's bank. A burst started with auto_pre=0 gives no pre_req.
- R10: A burst that is ended by a new WRITE or by another command, and any full-page burst, never raises pre_req.
- R11: While cke=0 no command is decoded, mem_we=0, and a running burst holds its position. It resumes when cke returns to 1.
- R12: While rst_n=0 the burst state is cleared and pre_req=0. After reset, no write happens until a WRITE arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable; low suspends the block |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe pin |
| cas_n | input | 1 | Column strobe pin |
| we_n | input | 1 | Write enable pin |
| ba | input | BANK_W | Bank address sampled with the command |
| col_addr | input | COL_W | Starting column sampled with the command |
| auto_pre | input | 1 | Auto-precharge address bit sampled with the command |
| dq_in | input | DATA_W | Write data |
| burst_sel | input | 3 | Static burst length code |
| burst_ilv | input | 1 | Static burst order: 0 sequential, 1 interleaved |
| mem_we | output | 1 | Array write strobe |
| mem_bank | output | BANK_W | Array bank |
| mem_col | output | COL_W | Array column |
| mem_wdata | output | DATA_W | Array write data |
| pre_req | output | 1 | Precharge request pulse |
| pre_bank | output | BANK_W | Bank to precharge |

## Verification
The precharge request for a finished auto-precharge burst can fall in the same cycle as the first word of the next WRITE. The bench provokes this by issuing the new WRITE to a different bank on the cycle right after the previous burst's last word. It passes only if the write goes to the new bank and column while pre_req names the old bank. A second overlap, a WRITE that lands in the middle of an auto-precharge burst, is judged by the absence of any precharge pulse on the cycles that follow.

// File: rtl/sdram_wb_pkg.sv
package sdram_wb_pkg;

  typedef enum logic [1:0] {
    WB_IDLE    = 2'd0,
    WB_WRITE   = 2'd1,
    WB_OTHER   = 2'd2,
    WB_SUSPEND = 2'd3
  } wb_cmd_e;

  function automatic logic [1:0] burst_log2(input logic [2:0] sel);
    return sel[1:0];
  endfunction

  function automatic logic burst_is_full(input logic [2:0] sel);
    return sel[2];
  endfunction

endpackage

// File: rtl/sdram_wb_cmd_dec.sv
module sdram_wb_cmd_dec
  import sdram_wb_pkg::*;
(
  input  logic    cke,
  input  logic    cs_n,
  input  logic    ras_n,
  input  logic    cas_n,
  input  logic    we_n,
  output wb_cmd_e cmd
);
  always_comb begin
    if (!cke)      cmd = WB_SUSPEND;
    else if (cs_n) cmd = WB_IDLE;
    else begin
      case ({ras_n, cas_n, we_n})
        3'b111:  cmd = WB_IDLE;
        3'b100:  cmd = WB_WRITE;
        default: cmd = WB_OTHER;
      endcase
    end
  end
endmodule

// File: rtl/sdram_wb_col_gen.sv
module sdram_wb_col_gen #(
  parameter int COL_W = 9
) (
  input  logic [COL_W-1:0] start_col,
  input  logic [COL_W-1:0] idx,
  input  logic [1:0]       l2,
  input  logic             full,
  input  logic             ilv,
  output logic [COL_W-1:0] col
);
  function automatic logic [COL_W-1:0] burst_col(
    input logic [COL_W-1:0] s, input logic [COL_W-1:0] i,
    input logic [1:0] lg, input logic fp, input logic il);
    logic [COL_W-1:0] mask;
    logic [COL_W-1:0] low;
    mask = COL_W'((32'd1 << lg) - 32'd1);
    if (fp) return s + i;
    low = il ? ((s ^ i) & mask) : ((s + i) & mask);
    return (s & ~mask) | low;
  endfunction

  assign col = burst_col(start_col, idx, l2, full, ilv);
endmodule

// File: rtl/sdram_wb_burst_ctl.sv
module sdram_wb_burst_ctl
  import sdram_wb_pkg::*;
#(
  parameter int COL_W  = 9,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  wb_cmd_e           cmd,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [COL_W-1:0]  cmd_col,
  input  logic              cmd_ap,
  input  logic [2:0]        burst_sel,
  input  logic              burst_ilv,
  output logic              st_active,
  output logic [COL_W-1:0]  st_idx,
  output logic [BANK_W-1:0] st_bank,
  output logic [COL_W-1:0]  st_start,
  output logic [1:0]        st_l2,
  output logic              st_full,
  output logic              st_ilv,
  output logic              last_word,
  output logic              pre_req,
  output logic [BANK_W-1:0] pre_bank
);
  function automatic logic [COL_W-1:0] final_idx(input logic [1:0] lg);
    return COL_W'((32'd1 << lg) - 32'd1);
  endfunction

  logic st_ap;
  logic new_single;
  logic step;
  logic trunc_evt;

  assign new_single = !burst_is_full(burst_sel) && (burst_log2(burst_sel) == 2'd0);
  assign step       = st_active && (cmd == WB_IDLE);
  assign trunc_evt  = st_active && (cmd == WB_WRITE);
  assign last_word  = ((cmd == WB_WRITE) && new_single) ||
                      (step && !st_full && (st_idx == final_idx(st_l2)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_active <= 1'b0;
      st_idx    <= '0;
      st_bank   <= '0;
      st_start  <= '0;
      st_l2     <= '0;
      st_full   <= 1'b0;
      st_ilv    <= 1'b0;
      st_ap     <= 1'b0;
      pre_req   <= 1'b0;
      pre_bank  <= '0;
    end else begin
      pre_req <= 1'b0;
      case (cmd)
        WB_WRITE: begin
          st_active <= !new_single;
          st_idx    <= COL_W'(1);
          st_bank   <= cmd_bank;
          st_start  <= cmd_col;
          st_ap     <= cmd_ap;
          st_l2     <= burst_log2(burst_sel);
          st_full   <= burst_is_full(burst_sel);
          st_ilv    <= burst_ilv;
          pre_req   <= cmd_ap && new_single;
          pre_bank  <= cmd_bank;
        end
        WB_IDLE: begin
          if (step) begin
            st_idx <= st_idx + COL_W'(1);
            if (last_word) begin
              st_active <= 1'b0;
              pre_req   <= st_ap;
              pre_bank  <= st_bank;
            end
          end
        end
        WB_OTHER: st_active <= 1'b0;
        default: ;
      endcase
    end
  end

  // R2: a step that is not the last keeps the burst running at the next index
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    step && !last_word |=> st_active && (st_idx == $past(st_idx) + COL_W'(1)));
  // R6: a full-page burst never reaches a last word on its own
  p_full_no_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    step && st_full |-> !last_word);
  // R10: a truncating WRITE of a multi-word burst gives no precharge next cycle
  p_trunc_no_pre_r10: assert property (@(posedge clk) disable iff (!rst_n)
    trunc_evt && !new_single |=> !pre_req);
  // R11: suspension freezes the burst position
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == WB_SUSPEND |=> $stable(st_idx) && $stable(st_active) && !pre_req);
  // R8: another command ends the burst without precharge
  p_other_stops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == WB_OTHER |=> !st_active && !pre_req);
endmodule

// File: rtl/sdram_wr_burst_seq.sv
module sdram_wr_burst_seq
  import sdram_wb_pkg::*;
#(
  parameter int COL_W  = 9,
  parameter int BANK_W = 2,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [BANK_W-1:0] ba,
  input  logic [COL_W-1:0]  col_addr,
  input  logic              auto_pre,
  input  logic [DATA_W-1:0] dq_in,
  input  logic [2:0]        burst_sel,
  input  logic              burst_ilv,
  output logic              mem_we,
  output logic [BANK_W-1:0] mem_bank,
  output logic [COL_W-1:0]  mem_col,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              pre_req,
  output logic [BANK_W-1:0] pre_bank
);
  wb_cmd_e           cmd;
  logic              is_wr;
  logic              st_active;
  logic [COL_W-1:0]  st_idx;
  logic [BANK_W-1:0] st_bank;
  logic [COL_W-1:0]  st_start;
  logic [1:0]        st_l2;
  logic              st_full;
  logic              st_ilv;
  logic              last_word;
  logic [COL_W-1:0]  g_start;
  logic [COL_W-1:0]  g_idx;
  logic [1:0]        g_l2;
  logic              g_full;
  logic              g_ilv;

  sdram_wb_cmd_dec u_dec (
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cmd(cmd)
  );

  sdram_wb_burst_ctl #(.COL_W(COL_W), .BANK_W(BANK_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .cmd_bank(ba), .cmd_col(col_addr),
    .cmd_ap(auto_pre), .burst_sel(burst_sel), .burst_ilv(burst_ilv),
    .st_active(st_active), .st_idx(st_idx), .st_bank(st_bank),
    .st_start(st_start), .st_l2(st_l2), .st_full(st_full), .st_ilv(st_ilv),
    .last_word(last_word), .pre_req(pre_req), .pre_bank(pre_bank)
  );

  assign is_wr   = (cmd == WB_WRITE);
  assign g_start = is_wr ? col_addr : st_start;
  assign g_idx   = is_wr ? '0 : st_idx;
  assign g_l2    = is_wr ? burst_log2(burst_sel) : st_l2;
  assign g_full  = is_wr ? burst_is_full(burst_sel) : st_full;
  assign g_ilv   = is_wr ? burst_ilv : st_ilv;

  sdram_wb_col_gen #(.COL_W(COL_W)) u_col (
    .start_col(g_start), .idx(g_idx), .l2(g_l2), .full(g_full), .ilv(g_ilv),
    .col(mem_col)
  );

  assign mem_we    = is_wr || (st_active && cmd == WB_IDLE);
  assign mem_bank  = is_wr ? ba : st_bank;
  assign mem_wdata = dq_in;

  // R1: the command cycle itself writes to the sampled bank and column
  p_write_now_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == WB_WRITE |-> mem_we && (mem_col == col_addr) && (mem_bank == ba));
  // R5: no burst running and no WRITE means no write
  p_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !st_active && cmd != WB_WRITE |-> !mem_we);
  // R9: a precharge request always follows a written word
  p_pre_after_word_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pre_req |-> $past(mem_we));
  // R3: fixed-burst columns stay inside the aligned block of the start column
  p_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we && !is_wr && !st_full |-> (mem_col >> st_l2) == (st_start >> st_l2));
  // R12: last_word never fires without a write strobe
  p_last_is_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
    last_word |-> mem_we);
endmodule

// File: tb/sdram_wr_burst_seq_test.sv
`timescale 1ns/1ps
module sdram_wr_burst_seq_test;
  localparam int C_NOP = 0, C_WR = 1, C_DES = 2, C_RD = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cke = 1'b1, cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] ba = '0;
  logic [8:0] col_addr = '0;
  logic       auto_pre = 1'b0;
  logic [15:0] dq_in = '0;
  logic [2:0] burst_sel = '0;
  logic       burst_ilv = 1'b0;
  logic       mem_we;
  logic [1:0] mem_bank;
  logic [8:0] mem_col;
  logic [15:0] mem_wdata;
  logic       pre_req;
  logic [1:0] pre_bank;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  sdram_wr_burst_seq uut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .col_addr(col_addr),
    .auto_pre(auto_pre), .dq_in(dq_in), .burst_sel(burst_sel),
    .burst_ilv(burst_ilv), .mem_we(mem_we), .mem_bank(mem_bank),
    .mem_col(mem_col), .mem_wdata(mem_wdata), .pre_req(pre_req),
    .pre_bank(pre_bank)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic put(input int c, input int bank, input int col, input bit ap,
                     input int data, input bit ck = 1'b1);
    @(negedge clk);
    cke = ck;
    cs_n = (c == C_DES);
    ras_n = 1'b1;
    cas_n = (c == C_WR || c == C_RD) ? 1'b0 : 1'b1;
    we_n = (c == C_WR) ? 1'b0 : 1'b1;
    ba = 2'(bank);
    col_addr = 9'(col);
    auto_pre = ap;
    dq_in = 16'(data);
    #1;
  endtask

  task automatic chk_word(input string tag, input int col, input int bank, input int data);
    chk(mem_we == 1'b1, {tag, " we"}, int'(mem_we), 1);
    chk(int'(mem_col) == col, {tag, " col"}, int'(mem_col), col);
    chk(int'(mem_bank) == bank, {tag, " bank"}, int'(mem_bank), bank);
    chk(int'(mem_wdata) == data, {tag, " data"}, int'(mem_wdata), data);
  endtask

  function automatic int exp_col(input int start, input int i, input int ls, input bit ilv);
    int len, off, base;
    if (ls >= 4) return (start + i) % 512;
    len = 1 << ls;
    off = start % len;
    base = start - off;
    if (ilv) return base + (off ^ i);
    return base + ((off + i) % len);
  endfunction

  initial begin
    repeat (60000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    put(C_NOP, 0, 0, 0, 0);
    put(C_NOP, 0, 0, 0, 0);
    chk(pre_req == 1'b0, "R12 pre in reset", int'(pre_req), 0);
    rst_n = 1'b1;
    put(C_NOP, 0, 0, 0, 0);
    chk(mem_we == 1'b0, "R12 idle after reset", int'(mem_we), 0);

    // R2 R3 R4 R5 R9: sweep fixed lengths, orders and start offsets
    for (int ls = 0; ls < 4; ls++) begin
      for (int il = 0; il < 2; il++) begin
        for (int s = 0; s < (1 << ls); s++) begin
          int start, bank;
          bit ap;
          start = 64 * (s % 4) + 16 * ls + s;
          bank = (s + ls) % 4;
          ap = bit'((s + il) % 2);
          burst_sel = 3'(ls);
          burst_ilv = bit'(il);
          put(C_WR, bank, start, ap, 1000 + s);
          chk_word("R1 cmd word", start, bank, 1000 + s);
          for (int i = 1; i < (1 << ls); i++) begin
            put(i % 3 == 2 ? C_DES : C_NOP, (bank + 1) % 4, 0, 0, 2000 + i);
            chk_word(il ? "R4 interleaved word" : "R3 sequential word",
                     exp_col(start, i, ls, bit'(il)), bank, 2000 + i);
          end
          put(C_NOP, 0, 0, 0, 3000);
          chk(mem_we == 1'b0, "R5 no write after burst", int'(mem_we), 0);
          chk(pre_req == ap, "R9 pre pulse", int'(pre_req), int'(ap));
          if (ap) chk(int'(pre_bank) == bank, "R9 pre bank", int'(pre_bank), bank);
          put(C_NOP, 0, 0, 0, 3001);
          chk(pre_req == 1'b0, "R9 pre one cycle", int'(pre_req), 0);
          chk(mem_we == 1'b0, "R5 still quiet", int'(mem_we), 0);
        end
      end
    end

    // R6 R8 R10: full page wraps, interleave ignored, ended by another command
    burst_sel = 3'd5;
    burst_ilv = 1'b1;
    put(C_WR, 2, 509, 1, 500);
    chk_word("R6 page start", 509, 2, 500);
    for (int i = 1; i < 7; i++) begin
      put(i == 4 ? C_DES : C_NOP, 0, 0, 0, 500 + i);
      chk_word("R6 page wrap", (509 + i) % 512, 2, 500 + i);
    end
    put(C_RD, 1, 33, 0, 9);
    chk(mem_we == 1'b0, "R8 other command no write", int'(mem_we), 0);
    put(C_NOP, 0, 0, 0, 9);
    chk(mem_we == 1'b0, "R8 burst ended", int'(mem_we), 0);
    chk(pre_req == 1'b0, "R10 no pre for page", int'(pre_req), 0);

    // R7 R10: truncation by a new WRITE to another bank
    burst_sel = 3'd3;
    burst_ilv = 1'b0;
    put(C_WR, 1, 16, 1, 40);
    put(C_NOP, 0, 0, 0, 41);
    put(C_NOP, 0, 0, 0, 42);
    put(C_WR, 2, 100, 0, 77);
    chk_word("R7 truncating write", 100, 2, 77);
    chk(pre_req == 1'b0, "R10 no pre at truncation", int'(pre_req), 0);
    for (int i = 1; i < 8; i++) begin
      put(C_NOP, 3, 0, 0, 80 + i);
      chk_word("R7 new burst", 96 + ((4 + i) % 8), 2, 80 + i);
      chk(pre_req == 1'b0, "R10 truncated no pre", int'(pre_req), 0);
    end
    put(C_NOP, 0, 0, 0, 0);
    chk(mem_we == 1'b0, "R5 after new burst", int'(mem_we), 0);
    chk(pre_req == 1'b0, "R9 no pre when ap off", int'(pre_req), 0);

    // R9 R7: precharge of finished burst coincides with next WRITE
    burst_sel = 3'd1;
    put(C_WR, 3, 6, 1, 60);
    put(C_NOP, 0, 0, 0, 61);
    chk_word("R2 second word", 7, 3, 61);
    put(C_WR, 0, 20, 1, 62);
    chk_word("R7 back to back", 20, 0, 62);
    chk(pre_req == 1'b1, "R9 overlap pre", int'(pre_req), 1);
    chk(pre_bank == 2'd3, "R9 overlap bank", int'(pre_bank), 3);
    put(C_NOP, 0, 0, 0, 63);
    chk_word("R2 next word", 21, 0, 63);
    chk(pre_req == 1'b0, "R9 pre dropped", int'(pre_req), 0);
    put(C_NOP, 0, 0, 0, 0);
    chk(pre_req == 1'b1 && pre_bank == 2'd0, "R9 second pre", int'({pre_req, pre_bank}), 4);

    // R11: clock enable low suspends
    burst_sel = 3'd2;
    put(C_WR, 1, 13, 1, 70);
    chk_word("R1 cke burst", 13, 1, 70);
    put(C_NOP, 0, 0, 0, 71);
    chk_word("R3 cke burst", 14, 1, 71);
    put(C_NOP, 0, 0, 0, 72, 1'b0);
    chk(mem_we == 1'b0, "R11 suspended", int'(mem_we), 0);
    put(C_WR, 2, 200, 1, 73, 1'b0);
    chk(mem_we == 1'b0, "R11 write ignored", int'(mem_we), 0);
    chk(pre_req == 1'b0, "R11 no pre", int'(pre_req), 0);
    put(C_NOP, 0, 0, 0, 74);
    chk_word("R11 resume", 15, 1, 74);
    put(C_NOP, 0, 0, 0, 75);
    chk_word("R11 resume wrap", 12, 1, 75);
    put(C_NOP, 0, 0, 0, 0);
    chk(mem_we == 1'b0, "R5 after resume", int'(mem_we), 0);
    chk(pre_req == 1'b1 && pre_bank == 2'd1, "R9 after resume", int'({pre_req, pre_bank}), 5);

    // R12: reset mid-burst
    burst_sel = 3'd3;
    put(C_WR, 0, 40, 1, 90);
    put(C_NOP, 0, 0, 0, 91);
    @(negedge clk);
    rst_n = 1'b0;
    put(C_NOP, 0, 0, 0, 0);
    rst_n = 1'b1;
    put(C_NOP, 0, 0, 0, 0);
    chk(mem_we == 1'b0, "R12 reset clears burst", int'(mem_we), 0);
    chk(pre_req == 1'b0, "R12 reset clears pre", int'(pre_req), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule